// File: doc/BRIEF.md
# Synchronous Bus Master with Wait-State Insertion

This block sits on the processor side of a single-clock memory bus and turns one user request into one read or one write bus cycle. Every agent on the bus shares the same clock and the same rate. A transfer is built from named phases. T1 presents the address, the strobe and the direction. T2 gives the memory time to respond. T3 completes the transfer. Between T2 and T3 the memory can stretch the cycle by holding its wait line high. Each sampled-high cycle adds one Tw phase.

The user side is a plain request/done handshake. A request is taken only while the master is idle. It carries a direction, an address and write data. A one-cycle done pulse reports completion, and for reads the captured word is presented with it. The shared data lines are split into an outgoing word, an output enable and an incoming word, so the tri-state buffer sits in the pad ring. The enable is raised only while the master owns the lines for a write.

Top module: `sbus_master`

## Requirements
- R1: While reset is applied and after it is released, with no request, `bus_astb`, `bus_doe` and `done` are 0.
- R2: A request sampled high on a rising edge while idle starts a transfer. In the next cycle (T1), `bus_astb` is 1, `bus_addr` equals the requested address, and `bus_rd` is 1 for a read (`req_write`=0) or 0 for a write.
- R3: `bus_addr` and `bus_rd` stay unchanged for every cycle in which `bus_astb` is 1.
- R4: With `bus_wait` low throughout, `bus_astb` is high for exactly 3 consecutive cycles (T1, T2, T3).
- R5: `bus_wait` is sampled only at the end of T2 and of each Tw. Each high sample adds one Tw cycle, so N consecutive high samples give a strobe of 3+N cycles. A high `bus_wait` during T1 or T3 has no effect.
- R6: During a write, `bus_doe` is 1 and `bus_dout` equals the request's write data in every strobe cycle.
- R7: During a read, `bus_doe` stays 0. `rd_data` takes the value of `bus_din` sampled on the rising edge that ends T3.
- R8: `done` is 1 for exactly one cycle: the first cycle after T3, when `bus_astb` has returned to 0.
- R9: A request raised while a transfer is in progress is ignored. It changes neither the address nor the strobe, and if it is withdrawn before completion, no transfer follows.
- R10: `bus_doe` is 0 whenever `bus_astb` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock shared by all agents |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Transfer request, honoured only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Requested memory address |
| req_wdata | input | DATA_W | Word to write |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Word captured by the last read |
| bus_addr | output | ADDR_W | Address lines |
| bus_astb | output | 1 | Address strobe, high T1 through T3 |
| bus_rd | output | 1 | Direction line, 1 = read, 0 = write |
| bus_dout | output | DATA_W | Outgoing data to the tri-state pad |
| bus_doe | output | 1 | Tri-state enable for the data lines |
| bus_din | input | DATA_W | Incoming data from the data lines |
| bus_wait | input | 1 | Memory wait request |

## Verification
The hardest situation to reach is a wait line that is high outside the window in which it counts: in T1, or in T3 just after a run of real waits. A master that samples the line one phase early or late would add or drop a cycle. The bench's memory model builds the wait line from its own count of strobe cycles. Given a chosen number of waits, it can also raise spurious high levels in T1 and T3. Random transfers mix these patterns, and the bench measures the strobe length against 3+N. A second hard case is a request raised in the middle of a transfer. The bench pulses it with a different address and then checks that the address holds and that no further strobe follows the done pulse.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_TW   = 3'd3,
    PH_T3   = 3'd4
  } sbus_phase_e;
endpackage

// File: rtl/sbus_rst_sync.sv
module sbus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sbus_phase_seq.sv
module sbus_phase_seq
  import sbus_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        bus_wait,
  output sbus_phase_e phase
);
  sbus_phase_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE: if (start) state_d = PH_T1;
      PH_T1:   state_d = PH_T2;
      PH_T2,
      PH_TW:   state_d = bus_wait ? PH_TW : PH_T3;
      PH_T3:   state_d = PH_IDLE;
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_IDLE;
    else        state_q <= state_d;
  end

  assign phase = state_q;

  AST_T1_TO_T2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_T1) |=> (state_q == PH_T2));                                   // R4
  AST_WAIT_ADDS_TW: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PH_T2 || state_q == PH_TW) && bus_wait) |=> (state_q == PH_TW));  // R5
  AST_NO_WAIT_TO_T3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PH_T2 || state_q == PH_TW) && !bus_wait) |=> (state_q == PH_T3)); // R5
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PH_IDLE && state_q != PH_T3) |=> (state_q != PH_T1));            // R9
endmodule

// File: rtl/sbus_xfer_regs.sv
module sbus_xfer_regs
  import sbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              in_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  sbus_phase_e       phase,
  input  logic [DATA_W-1:0] bus_din,
  output logic              held_write,
  output logic [ADDR_W-1:0] held_addr,
  output logic [DATA_W-1:0] held_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);
  logic              write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q;
  logic              cap_en;
  logic              done_d;

  assign cap_en = (phase == PH_T3) && !write_q;
  assign done_d = (phase == PH_T3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load) begin
      write_q <= in_write;
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= bus_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign held_write = write_q;
  assign held_addr  = addr_q;
  assign held_wdata = wdata_q;
  assign rd_data    = rdata_q;
  assign done       = done_q;

  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> ($stable(addr_q) && $stable(write_q)));   // R3
  AST_RDATA_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (write_q && !load) |=> $stable(rdata_q));                        // R7
endmodule

// File: rtl/sbus_master.sv
module sbus_master
  import sbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_astb,
  output logic              bus_rd,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_wait
);
  logic              rst_n_s;
  sbus_phase_e       phase;
  logic              idle;
  logic              accept;
  logic              held_write;
  logic [ADDR_W-1:0] held_addr;
  logic [DATA_W-1:0] held_wdata;

  sbus_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign idle   = (phase == PH_IDLE);
  assign accept = idle && req;

  sbus_phase_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start    (accept),
    .bus_wait (bus_wait),
    .phase    (phase)
  );

  sbus_xfer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .load       (accept),
    .in_write   (req_write),
    .in_addr    (req_addr),
    .in_wdata   (req_wdata),
    .phase      (phase),
    .bus_din    (bus_din),
    .held_write (held_write),
    .held_addr  (held_addr),
    .held_wdata (held_wdata),
    .rd_data    (rd_data),
    .done       (done)
  );

  assign bus_astb = !idle;
  assign bus_addr = held_addr;
  assign bus_rd   = idle ? 1'b1 : !held_write;
  assign bus_doe  = !idle && held_write;
  assign bus_dout = held_wdata;

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_astb |=> (!bus_astb || ($stable(bus_addr) && $stable(bus_rd))));  // R3
  AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_doe |-> (bus_astb && !bus_rd));                                  // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    !bus_astb |-> !bus_doe);                                             // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !done);                                                     // R8
  AST_T3_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (phase == PH_T3) |=> (done && !bus_astb));                           // R8
  AST_START_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n_s)
    accept |=> (bus_astb && $past(req_addr) == bus_addr));               // R2
endmodule

// File: tb/sim_sbus_master.sv
module sim_sbus_master;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic          req;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          done;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] bus_addr;
  logic          bus_astb;
  logic          bus_rd;
  logic [DW-1:0] bus_dout;
  logic          bus_doe;
  logic [DW-1:0] bus_din;
  logic          bus_wait;

  int checks;
  int failures;
  int cyc;
  int nwait_cur;
  bit noise_cur;
  logic [DW-1:0] mem    [16];
  logic [DW-1:0] shadow [16];

  sbus_master #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rd_data(rd_data),
    .bus_addr(bus_addr), .bus_astb(bus_astb), .bus_rd(bus_rd),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din), .bus_wait(bus_wait)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // memory model: counts strobe cycles, drives wait and read data
  always @(posedge clk) begin
    if (bus_astb) begin
      if (!bus_rd && bus_doe && cyc == 2 + nwait_cur) mem[bus_addr[3:0]] <= bus_dout;
      cyc <= cyc + 1;
    end else begin
      cyc <= 0;
    end
  end

  always_comb begin
    bus_wait = bus_astb && ((cyc >= 1 && cyc < 1 + nwait_cur) ||
               (noise_cur && (cyc == 0 || cyc == 2 + nwait_cur)));
    bus_din  = (bus_astb && bus_rd) ? mem[bus_addr[3:0]] : '0;
  end

  function automatic int exp_len(input int nw);
    return 3 + nw;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int nw, input bit noise, input bit poke);
    int len;
    @(negedge clk);
    nwait_cur = nw;
    noise_cur = noise;
    req = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
    chk(bus_astb == 1'b1, "R2 strobe in T1", bus_astb, 1);
    chk(bus_addr == a, "R2 address in T1", bus_addr, a);
    chk(bus_rd == !wr, "R2 direction in T1", bus_rd, !wr);
    len = 0;
    while (bus_astb && len < 100) begin
      if (bus_addr != a || bus_rd != !wr) chk(1'b0, "R3 address/direction held", bus_addr, a);
      if (wr) begin
        if (!bus_doe || bus_dout != d) chk(1'b0, "R6 write drive", bus_dout, d);
      end else if (bus_doe) begin
        chk(1'b0, "R7 no drive on read", bus_doe, 0);
      end
      if (done) chk(1'b0, "R8 done during strobe", done, 0);
      if (poke && len == 1) begin
        req = 1'b1; req_write = !wr; req_addr = a ^ 16'h0005;
      end else begin
        req = 1'b0;
      end
      len++;
      @(negedge clk);
    end
    req = 1'b0;
    chk(len == exp_len(nw), nw == 0 ? "R4 strobe length" : "R5 strobe length", len, exp_len(nw));
    chk(done == 1'b1, "R8 done after T3", done, 1);
    chk(bus_doe == 1'b0, "R10 enable low when idle", bus_doe, 0);
    if (wr) shadow[a[3:0]] = d;
    else chk(rd_data == shadow[a[3:0]], "R7 read data", rd_data, shadow[a[3:0]]);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", done, 0);
    if (poke) chk(bus_astb == 1'b0, "R9 busy request ignored", bus_astb, 0);
    noise_cur = 1'b0;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int unused;
    checks = 0; failures = 0;
    nwait_cur = 0; noise_cur = 1'b0;
    req = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'hA500_0000 + DW'(i);
      shadow[i] = 32'hA500_0000 + DW'(i);
    end
    unused = $urandom(32'd1234);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bus_astb && !bus_doe && !done, "R1 reset quiet", {bus_astb, bus_doe, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!bus_astb && !bus_doe && !done, "R1 idle after reset", {bus_astb, bus_doe, done}, 0);

    // directed corners
    run_xfer(1'b0, 16'h0003, '0, 0, 1'b0, 1'b0);                // R4 read, no wait
    run_xfer(1'b1, 16'h0003, 32'hDEAD_BEEF, 0, 1'b0, 1'b0);     // R6 write
    run_xfer(1'b0, 16'h0003, '0, 1, 1'b0, 1'b0);                // R5 one wait
    run_xfer(1'b1, 16'h1007, 32'h1234_5678, 4, 1'b0, 1'b0);     // R5 several waits
    run_xfer(1'b0, 16'h1007, '0, 0, 1'b1, 1'b0);                // R5 wait only in T1/T3
    run_xfer(1'b0, 16'h0009, '0, 2, 1'b1, 1'b1);                // R9 poke while busy

    // random mix
    for (int k = 0; k < 60; k++) begin
      run_xfer(1'($urandom), 16'($urandom), $urandom, int'($urandom % 5),
               1'($urandom), ($urandom % 4) == 0);
    end

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule